// File: doc/BRIEF.md
# Serial Quad Wiper Register Interface

This block is the serial front end of a four-channel, 8-bit setting store. A host talks to it over three wires (a serial clock, an active-high select and a data input) and reads back on a data output that it can tri-state. Each transfer names one channel and carries one new byte. While the new byte shifts in, the byte that register held shifts out. Every write is therefore also a destructive read.

Each channel has a volatile working register and a nonvolatile shadow copy. The shadow copy is modelled as a plain register. The working registers drive the outputs. A transfer changes only the working register unless the program input is high when the new value is committed, in which case the shadow is updated as well. Whenever select is low, every working register is reloaded from its shadow. Select thus works as a revert-to-stored control. Trial settings last only while select stays high.

All inputs are synchronous to the system clock `clk`. A serial clock edge is a rising transition of `ser_clk` between two samples of `clk`. In the text below, a "serial rise" means the `clk` edge at which that transition is first seen.

Top module: `serial_quad_wiper`

## Requirements
- R1: After `rst_n` is released, every working register and every shadow holds its value from the `INIT` parameter, with channel k in `wipers[8k+7:8k]`. No serial clock edge is needed for this.
- R2: While select is high and no frame is in progress, a serial rise with `di` = 0 is ignored. Only a serial rise with `di` = 1 starts a frame.
- R3: A frame is a start bit of 1, then address bit A0, then address bit A1, then eight data bits sent least-significant bit first. The channel index is {A1,A0}, so A0 is the index LSB.
- R4: Between the serial rise of A1 and the serial rise of data bit 0, `do_out` carries bit 0 of the addressed channel's old value. Each data-bit serial rise moves it on to the next old bit. Outside the data phase, `do_out` is 0.
- R5: The addressed working register takes the new byte on the serial rise that follows data bit 7, and not earlier. The other channels keep their values.
- R6: `do_oe` is high exactly when select is high. While select is low, `do_out` is 0.
- R7: While select is low, all four working registers are reloaded from their shadows.
- R8: If `prog` is high at the commit serial rise, the addressed shadow also takes the new byte. Otherwise the shadows do not change.
- R9: The two serial rises after data bit 7 ignore `di`. The earliest start bit of the next frame is on the third serial rise after data bit 7.
- R10: If select falls during a frame, the frame is abandoned with no update to any working register or shadow. The next frame is parsed from its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, loads the INIT values |
| ser_clk | input | 1 | Serial clock; its rising transitions are detected |
| cs | input | 1 | Active-high select |
| di | input | 1 | Serial data in |
| prog | input | 1 | Store-to-shadow request, sampled at commit |
| do_out | output | 1 | Serial data out |
| do_oe | output | 1 | Output enable for the tri-state driver on do_out |
| wipers | output | NCH*W | Working registers, channel k at bits [8k+7:8k] |

## Verification
The hardest states to reach are a select drop partway through the data phase and a start bit offered during the two dead serial rises after data bit 7. Neither state is reached by well-formed transfers. The bench builds both on purpose. It abandons a frame after five data bits, while `prog` is high, and then checks that neither the working registers nor the shadows have changed. It also drives `di` high through the commit and gap rises, then confirms that the next frame still decodes its address correctly. Random frames with random `prog` values and random select drops then mix trial and stored values across all four channels.

// File: rtl/serial_quad_wiper.sv
module serial_quad_wiper #(
  parameter int W = 8,
  parameter int NCH = 4,
  parameter logic [NCH*W-1:0] INIT = 32'h80_40_C0_10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             cs,
  input  logic             di,
  input  logic             prog,
  output logic             do_out,
  output logic             do_oe,
  output logic [NCH*W-1:0] wipers
);
  localparam int AW = $clog2(NCH);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_COMMIT, S_GAP} st_t;

  st_t st;
  logic sclk_d;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [W-1:0] sh;
  logic [NCH-1:0][W-1:0] work, shadow;

  wire rise = ser_clk & ~sclk_d;
  wire [AW-1:0] nxt_addr = (addr >> 1) | (AW'(di) << (AW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      st     <= S_IDLE;
      cnt    <= '0;
      addr   <= '0;
      sh     <= '0;
      work   <= INIT;
      shadow <= INIT;
    end else begin
      sclk_d <= ser_clk;
      if (!cs) begin
        st   <= S_IDLE;
        cnt  <= '0;
        work <= shadow;
      end else if (rise) begin
        case (st)
          S_IDLE: if (di) begin
            st  <= S_ADDR;
            cnt <= '0;
          end
          S_ADDR: begin
            addr <= nxt_addr;
            if (cnt == CW'(AW - 1)) begin
              st  <= S_DATA;
              cnt <= '0;
              sh  <= work[nxt_addr];
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            sh <= {di, sh[W-1:1]};
            if (cnt == CW'(W - 1)) begin
              st  <= S_COMMIT;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_COMMIT: begin
            work[addr] <= sh;
            if (prog) shadow[addr] <= sh;
            st <= S_GAP;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign do_oe  = cs;
  assign do_out = cs & (st == S_DATA) & sh[0];
  assign wipers = work;

  a_r7_revert: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (work == shadow));

  a_r5_hold_outside_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && st != S_COMMIT) |=> $stable(work));

  a_r8_shadow_only_on_prog: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && st == S_COMMIT && rise && prog) |=> $stable(shadow));

  a_r9_gap_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && st == S_GAP && rise) |=> (st == S_IDLE));

  a_r6_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !do_oe |-> !do_out);
endmodule

// File: tb/test_serial_quad_wiper.sv
module test_serial_quad_wiper;
  localparam logic [31:0] INIT = 32'h80_40_C0_10;
  logic clk = 0, rst_n = 0, ser_clk = 0, cs = 0, di = 0, prog = 0;
  logic do_out, do_oe;
  logic [31:0] wipers;
  logic [7:0] ew [4];
  logic [7:0] es [4];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  serial_quad_wiper i_serial_quad_wiper (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .cs(cs), .di(di), .prog(prog),
    .do_out(do_out), .do_oe(do_oe), .wipers(wipers));

  always #4 clk = ~clk;

  function automatic logic [31:0] pack_exp();
    return {ew[3], ew[2], ew[1], ew[0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    di = b; ser_clk = 0; tick(2);
    ser_clk = 1; tick(2);
  endtask

  task automatic drop_cs();
    cs = 0; tick(3);
    check("R6 oe low", {31'd0, do_oe}, 32'd0);
    check("R6 do quiet", {31'd0, do_out}, 32'd0);
    for (int k = 0; k < 4; k++) ew[k] = es[k];
    check("R7 revert", wipers, pack_exp());
    cs = 1; tick(2);
    check("R6 oe high", {31'd0, do_oe}, 32'd1);
  endtask

  task automatic frame(input logic [1:0] a, input logic [7:0] d, input logic p, input logic tail);
    logic [7:0] got;
    prog = p;
    sbit(1'b1); sbit(a[0]); sbit(a[1]);
    for (int i = 0; i < 8; i++) begin
      got[i] = do_out;
      sbit(d[i]);
    end
    check("R4 do idle after data", {31'd0, do_out}, 32'd0);
    check("R4 readback", {24'd0, got}, {24'd0, ew[a]});
    check("R5 no early update", wipers, pack_exp());
    sbit(tail);
    ew[a] = d;
    if (p) es[a] = d;
    check("R5 update", wipers, pack_exp());
    sbit(tail);
    prog = 0;
  endtask

  initial begin
    void'($urandom(32'd725));
    for (int k = 0; k < 4; k++) begin ew[k] = INIT[8*k +: 8]; es[k] = INIT[8*k +: 8]; end
    tick(3);
    check("R1 reset wipers", wipers, INIT);
    rst_n = 1; tick(2);
    check("R1 after release", wipers, INIT);
    check("R6 oe at reset", {31'd0, do_oe}, 32'd0);
    cs = 1; tick(2);
    for (int i = 0; i < 5; i++) sbit(1'b0);
    check("R2 zeros ignored", wipers, pack_exp());
    check("R2 do idle", {31'd0, do_out}, 32'd0);
    frame(2'b01, 8'hA5, 1'b0, 1'b0);
    frame(2'b10, 8'h3C, 1'b0, 1'b1);
    frame(2'b11, 8'hF0, 1'b1, 1'b0);
    check("R3 channel lanes", wipers, {8'hF0, 8'h3C, 8'hA5, 8'h10});
    frame(2'b01, 8'h11, 1'b0, 1'b1);
    frame(2'b00, 8'h77, 1'b0, 1'b0);
    check("R9 tail ignored", wipers, pack_exp());
    drop_cs();
    check("R8 stored channel kept", {24'd0, wipers[31:24]}, 32'hF0);
    prog = 1;
    sbit(1'b1); sbit(1'b0); sbit(1'b1);
    for (int i = 0; i < 5; i++) sbit(1'b1);
    drop_cs();
    check("R10 no partial shadow", {24'd0, wipers[23:16]}, {24'd0, INIT[23:16]});
    prog = 0;
    frame(2'b10, 8'h5A, 1'b0, 1'b0);
    check("R10 clean restart", {24'd0, wipers[23:16]}, 32'h5A);
    for (int it = 0; it < 60; it++) begin
      frame(2'($urandom_range(0, 3)), 8'($urandom), ($urandom_range(0, 3) == 0), 1'($urandom));
      if ($urandom_range(0, 5) == 0) drop_cs();
      if ($urandom_range(0, 3) == 0) sbit(1'b0);
    end
    drop_cs();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule